// File: doc/BRIEF.md
# Ordered Four-Rail Power Sequencer

This block brings four supply rails up one after another and takes them down again in the opposite order. It is the digital core of a sequencer: the analog gate drivers sit outside it and send back two status bits per rail, one saying the gate is close to full drive and one saying it has fallen below the off threshold. Each step waits on the preceding rail's status and not on a fixed timer. An active-low reset output is released only after every rail has been fully up for a programmable settling time.

Start-up is held off until all four undervoltage-OK levels and the active-low enable have been good without a break for a programmable lock-out time. A dropped undervoltage-OK level shuts every rail at once. If the drop outlasts a filter time, the block also pulls a shared kill line low. That line is a wired-AND net joining several sequencers. Any of them can pull it low to stop all rails everywhere. When the line is let go and every condition is already met, start-up begins at once and skips the lock-out.

Top module: `railseq_top`

## Requirements
- R1: While reset is applied and on the first cycle after it, all gate enables are 0, the reset output is low and the kill output is high.
- R2: Rail A (gate_en bit 0) turns on only after uv_ok is 4'b1111, en_n is 0 and the kill level is high for LOCK_CYC consecutive clock edges. Any break in these conditions restarts the count from zero.
- R3: Rails turn on in the order A, B, C, D (gate_en bits 0 to 3). Gate n+1 turns on on the edge after gate_near[n] is seen high. Until then it stays off, however long that takes.
- R4: rst_out_n goes high exactly RST_DLY_CYC edges after the edge on which gate_near[3] is seen with all four gates on.
- R5: Any uv_ok bit at 0 turns all four gates off and drives rst_out_n low on the next edge.
- R6: Once en_n goes high, rst_out_n goes low and gate D turns off on the next edge. Gates C, B and A then turn off one at a time. Each waits for gate_low of the gate that was turned off just before it.
- R7: kill_in low turns all gates off and drives rst_out_n low on the next edge, in every state. While kill_in stays low, no rail turns on.
- R8: On the edge where kill_in is seen high after having been low, if uv_ok is all ones and en_n is low, rail A turns on immediately without the lock-out wait.
- R9: kill_out_n goes low after any uv_ok bit has been 0 for FILT_CYC consecutive edges. It stays high for shorter drops and returns high on the edge where all uv_ok bits are 1 again.
- R10: After a fault clears, the lock-out and the turn-on sequence restart on their own, with no other input activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_ok | input | 4 | Undervoltage-OK level per rail, 1 = rail input good |
| en_n | input | 1 | Active-low sequence enable |
| kill_in | input | 1 | Sensed level of the shared kill net, low = kill |
| gate_near | input | 4 | Per-gate status: drive close to full |
| gate_low | input | 4 | Per-gate status: drive below off threshold |
| gate_en | output | 4 | Gate enables, bit 0 = A ... bit 3 = D |
| rst_out_n | output | 1 | Active-low reset to the powered system |
| kill_out_n | output | 1 | Open-drain-style pull on the shared kill net, low = pull down |

## Verification
The hardest case to reach is the lock-out bypass. It needs the kill net released while every other start condition is already met, so that the lock-out counter, cleared while the net was low, has not yet run. The stimulus runs a full ramp, pulls kill_in low in the on state, holds it for several cycles and then releases it. It then expects rail A on the very next edge, long before a lock-out could expire. The filter is probed from both sides: a short undervoltage drop must leave the kill output high, and a long one must pull it low on exactly the FILT_CYC-th edge.

// File: rtl/railseq_pkg.sv
package railseq_pkg;

    localparam int NUM_RAILS = 4;
    localparam int IDX_W     = $clog2(NUM_RAILS);

    typedef logic [NUM_RAILS-1:0] rail_vec_t;
    typedef logic [IDX_W-1:0]     rail_idx_t;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_UP   = 3'd1,
        SQ_HOLD = 3'd2,
        SQ_ON   = 3'd3,
        SQ_DOWN = 3'd4
    } seq_state_t;

    localparam rail_idx_t LAST_IDX = rail_idx_t'(NUM_RAILS - 1);

    // Mask of all rails strictly below index i.
    function automatic rail_vec_t below_mask(input rail_idx_t i);
        rail_vec_t m;
        for (int k = 0; k < NUM_RAILS; k++) begin
            m[k] = (k < int'(i));
        end
        return m;
    endfunction

    // Mask of all rails up to and including index i.
    function automatic rail_vec_t upto_mask(input rail_idx_t i);
        rail_vec_t m;
        for (int k = 0; k < NUM_RAILS; k++) begin
            m[k] = (k <= int'(i));
        end
        return m;
    endfunction

endpackage

// File: rtl/railseq_lockout.sv
module railseq_lockout #(
    parameter int LOCK_CYC = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hit
);
    localparam int CW = $clog2(LOCK_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCK_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign hit = run && (cnt == LAST);
endmodule

// File: rtl/railseq_uvfilter.sv
module railseq_uvfilter #(
    parameter int FILT_CYC = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic uv_all,
    output logic kill_out_n
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] LIMIT = FW'(FILT_CYC);

    logic [FW-1:0] bad_cnt;

    always_ff @(posedge clk) begin
        if (rst || uv_all) begin
            bad_cnt <= '0;
        end else if (bad_cnt != LIMIT) begin
            bad_cnt <= bad_cnt + 1'b1;
        end
    end

    assign kill_out_n = (bad_cnt != LIMIT);
endmodule

// File: rtl/railseq_fsm.sv
module railseq_fsm
    import railseq_pkg::*;
#(
    parameter int RST_DLY_CYC = 16000000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      uv_all,
    input  logic      en_n,
    input  logic      kill_in,
    input  logic      kill_eff,
    input  logic      lock_hit,
    input  rail_vec_t gate_near,
    input  rail_vec_t gate_low,
    output logic      lock_run,
    output rail_vec_t gate_en,
    output logic      rst_out_n
);
    localparam int HW = $clog2(RST_DLY_CYC + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(RST_DLY_CYC - 1);

    seq_state_t    st;
    rail_idx_t     idx;
    rail_vec_t     mask;
    logic [HW-1:0] hcnt;
    logic          kill_prev;
    logic          go_ok;
    logic          bypass;
    logic          fault;

    assign go_ok    = uv_all && !en_n;
    assign fault    = !uv_all || !kill_eff;
    assign bypass   = !kill_prev && kill_in && go_ok && kill_eff;
    assign lock_run = (st == SQ_IDLE) && go_ok && kill_eff;

    always_ff @(posedge clk) begin
        if (rst) begin
            kill_prev <= 1'b1;
        end else begin
            kill_prev <= kill_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || fault) begin
            st   <= SQ_IDLE;
            idx  <= '0;
            mask <= '0;
            hcnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (lock_hit || bypass) begin
                        st   <= SQ_UP;
                        idx  <= '0;
                        mask <= upto_mask('0);
                    end
                end
                SQ_UP: begin
                    if (en_n) begin
                        st   <= SQ_DOWN;
                        mask <= below_mask(idx);
                    end else if (gate_near[idx]) begin
                        if (idx == LAST_IDX) begin
                            st   <= SQ_HOLD;
                            hcnt <= '0;
                        end else begin
                            idx  <= idx + 1'b1;
                            mask <= upto_mask(idx + 1'b1);
                        end
                    end
                end
                SQ_HOLD: begin
                    if (en_n) begin
                        st   <= SQ_DOWN;
                        mask <= below_mask(idx);
                    end else if (hcnt == HOLD_LAST) begin
                        st <= SQ_ON;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
                SQ_ON: begin
                    if (en_n) begin
                        st   <= SQ_DOWN;
                        mask <= below_mask(idx);
                    end
                end
                SQ_DOWN: begin
                    if (gate_low[idx]) begin
                        if (idx == '0) begin
                            st <= SQ_IDLE;
                        end else begin
                            idx  <= idx - 1'b1;
                            mask <= below_mask(idx - 1'b1);
                        end
                    end
                end
                default: begin
                    st   <= SQ_IDLE;
                    mask <= '0;
                end
            endcase
        end
    end

    assign gate_en   = mask;
    assign rst_out_n = (st == SQ_ON);
endmodule

// File: rtl/railseq_top.sv
module railseq_top
    import railseq_pkg::*;
#(
    parameter int LOCK_CYC    = 1000000,
    parameter int RST_DLY_CYC = 16000000,
    parameter int FILT_CYC    = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] uv_ok,
    input  logic       en_n,
    input  logic       kill_in,
    input  logic [3:0] gate_near,
    input  logic [3:0] gate_low,
    output logic [3:0] gate_en,
    output logic       rst_out_n,
    output logic       kill_out_n
);
    logic uv_all;
    logic kill_eff;
    logic lock_run;
    logic lock_hit;

    assign uv_all   = &uv_ok;
    assign kill_eff = kill_in && kill_out_n;

    railseq_uvfilter #(.FILT_CYC(FILT_CYC)) filt_i (
        .clk        (clk),
        .rst        (rst),
        .uv_all     (uv_all),
        .kill_out_n (kill_out_n)
    );

    railseq_lockout #(.LOCK_CYC(LOCK_CYC)) lock_i (
        .clk (clk),
        .rst (rst),
        .run (lock_run),
        .hit (lock_hit)
    );

    railseq_fsm #(.RST_DLY_CYC(RST_DLY_CYC)) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .uv_all    (uv_all),
        .en_n      (en_n),
        .kill_in   (kill_in),
        .kill_eff  (kill_eff),
        .lock_hit  (lock_hit),
        .gate_near (gate_near),
        .gate_low  (gate_low),
        .lock_run  (lock_run),
        .gate_en   (gate_en),
        .rst_out_n (rst_out_n)
    );
endmodule

// File: rtl/railseq_chk.sv
module railseq_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] uv_ok,
    input logic       en_n,
    input logic       kill_in,
    input logic [3:0] gate_near,
    input logic [3:0] gate_en,
    input logic       rst_out_n,
    input logic       kill_out_n
);
    assert_uv_drop_R5: assert property (@(posedge clk) disable iff (rst)
        !(&uv_ok) |=> (gate_en == 4'b0000) && !rst_out_n);

    assert_kill_in_R7: assert property (@(posedge clk) disable iff (rst)
        !kill_in |=> (gate_en == 4'b0000) && !rst_out_n);

    assert_rst_all_on_R4: assert property (@(posedge clk) disable iff (rst)
        rst_out_n |-> (gate_en == 4'b1111));

    assert_killout_cause_R9: assert property (@(posedge clk) disable iff (rst)
        !kill_out_n |-> !$past(&uv_ok));

    assert_enable_drop_R6: assert property (@(posedge clk) disable iff (rst)
        en_n |=> !rst_out_n);

    for (genvar g = 1; g < 4; g++) begin : g_ord
        assert_step_R3: assert property (@(posedge clk) disable iff (rst)
            $rose(gate_en[g]) |-> $past(gate_near[g-1]) && gate_en[g-1]);
        assert_contig_R3: assert property (@(posedge clk) disable iff (rst)
            gate_en[g] |-> gate_en[g-1]);
    end
endmodule

bind railseq_top railseq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .uv_ok      (uv_ok),
    .en_n       (en_n),
    .kill_in    (kill_in),
    .gate_near  (gate_near),
    .gate_en    (gate_en),
    .rst_out_n  (rst_out_n),
    .kill_out_n (kill_out_n)
);

// File: tb/railseq_top_tb_top.sv
`timescale 1ns/1ps
module railseq_top_tb_top;
    localparam int LOCK = 16;
    localparam int RDLY = 24;
    localparam int FILT = 6;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] uv_ok;
    logic       en_n;
    logic       kill_in;
    logic [3:0] gate_near;
    logic [3:0] gate_low;
    logic [3:0] gate_en;
    logic       rst_out_n;
    logic       kill_out_n;

    always #2.5 clk = ~clk;

    railseq_top #(.LOCK_CYC(LOCK), .RST_DLY_CYC(RDLY), .FILT_CYC(FILT)) dut_i (
        .clk(clk), .rst(rst), .uv_ok(uv_ok), .en_n(en_n), .kill_in(kill_in),
        .gate_near(gate_near), .gate_low(gate_low), .gate_en(gate_en),
        .rst_out_n(rst_out_n), .kill_out_n(kill_out_n)
    );

    typedef struct {
        logic [3:0] gates;
        logic       rst_n;
        logic       kill_n;
        string      tag;
    } exp_t;

    exp_t q[$];
    event smp_ev;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    // Monitor: pops expected items and compares with the outputs.
    initial begin
        forever begin
            @(smp_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (gate_en !== e.gates || rst_out_n !== e.rst_n || kill_out_n !== e.kill_n) begin
                    bad++;
                    $display("FAIL %s: got gates=%b rst_n=%b kill_n=%b, expected gates=%b rst_n=%b kill_n=%b",
                             e.tag, gate_en, rst_out_n, kill_out_n, e.gates, e.rst_n, e.kill_n);
                end
            end
        end
    end

    task automatic expect_out(input logic [3:0] g, input logic r, input logic k, input string tag);
        exp_t e;
        e.gates = g; e.rst_n = r; e.kill_n = k; e.tag = tag;
        q.push_back(e);
        -> smp_ev;
        #0.1;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running, expected finished");
            finish_run();
        end
    end

    initial begin
        rst = 1; uv_ok = 4'hF; en_n = 1; kill_in = 1; gate_near = 0; gate_low = 0;
        tick(3);
        expect_out(4'b0000, 0, 1, "R1 during reset");
        rst = 0;
        tick(1);
        expect_out(4'b0000, 0, 1, "R1 after reset");

        // R2: lock-out with an interruption
        en_n = 0;
        tick(LOCK - 2);
        expect_out(4'b0000, 0, 1, "R2 before lock-out");
        en_n = 1; tick(1); en_n = 0;
        tick(LOCK - 2);
        expect_out(4'b0000, 0, 1, "R2 count restarted");
        tick(3);
        expect_out(4'b0001, 0, 1, "R2 lock-out expired");

        // R3: ordered ramp
        tick(3);
        expect_out(4'b0001, 0, 1, "R3 waits for near A");
        gate_near[0] = 1; tick(1);
        expect_out(4'b0011, 0, 1, "R3 B after A");
        gate_near[1] = 1; tick(1);
        expect_out(4'b0111, 0, 1, "R3 C after B");
        tick(2);
        expect_out(4'b0111, 0, 1, "R3 D waits for near C");
        gate_near[2] = 1; tick(1);
        expect_out(4'b1111, 0, 1, "R3 D after C");
        gate_near[3] = 1; tick(1);

        // R4: reset release delay
        tick(RDLY - 1);
        expect_out(4'b1111, 0, 1, "R4 still held");
        tick(1);
        expect_out(4'b1111, 1, 1, "R4 released");

        // R6: orderly shutdown
        en_n = 1; tick(1);
        expect_out(4'b0111, 0, 1, "R6 D off first");
        tick(3);
        expect_out(4'b0111, 0, 1, "R6 C waits for low D");
        gate_low[3] = 1; tick(1);
        expect_out(4'b0011, 0, 1, "R6 C off");
        gate_low[2] = 1; tick(1);
        expect_out(4'b0001, 0, 1, "R6 B off");
        gate_low[1] = 1; tick(1);
        expect_out(4'b0000, 0, 1, "R6 A off");
        gate_low[0] = 1; tick(1);
        gate_low = 0; gate_near = 0;

        // R5 and short fault for R9
        en_n = 0;
        tick(LOCK + 2);
        expect_out(4'b0001, 0, 1, "R10 restart after disable");
        gate_near = 4'hF; tick(3);
        expect_out(4'b1111, 0, 1, "R3 fast ramp");
        uv_ok = 4'b1011; tick(1);
        expect_out(4'b0000, 0, 1, "R5 uv drop kills all");
        tick(1);
        expect_out(4'b0000, 0, 1, "R9 short drop no kill");
        gate_near = 0; uv_ok = 4'hF;

        // R10: automatic restart
        tick(LOCK - 2);
        expect_out(4'b0000, 0, 1, "R10 waiting lock-out");
        tick(3);
        expect_out(4'b0001, 0, 1, "R10 auto restart");

        // R9: long drop
        uv_ok = 4'b0111;
        tick(FILT - 1);
        expect_out(4'b0000, 0, 1, "R9 before filter");
        tick(1);
        expect_out(4'b0000, 0, 0, "R9 kill asserted");
        uv_ok = 4'hF; tick(1);
        expect_out(4'b0000, 0, 1, "R9 kill released");

        // R7 and R8
        tick(LOCK + 2);
        gate_near = 4'hF; tick(3);
        expect_out(4'b1111, 0, 1, "R7 setup all on");
        kill_in = 0; tick(1);
        expect_out(4'b0000, 0, 1, "R7 kill-in shuts all");
        gate_near = 0;
        tick(LOCK + 2);
        expect_out(4'b0000, 0, 1, "R7 held off while killed");
        kill_in = 1; tick(1);
        expect_out(4'b0001, 0, 1, "R8 bypass on release");

        tick(2);
        done = 1;
        finish_run();
    end
endmodule